// File: doc/BRIEF.md
# Receive Buffer Pause Frame Generator

This block watches how much free space is left in a receive packet buffer and asks the MAC transmitter to send flow-control PAUSE frames to the link partner. When free space drops under a programmable entry threshold, it raises a pause-on request that carries a programmable non-zero quanta. When free space later climbs over a second, higher exit threshold, it raises a pause-off request with a quanta of zero. The gap between the two thresholds is the hysteresis band. Inside that band no request is made.

A two-state machine (running, paused) makes sure each threshold crossing produces exactly one request. A request stays up until the transmitter pulses a done input. While the block is paused, a refresh timer re-sends pause-on, so the partner's pause timer does not run out. Generation is allowed only when four things hold: the block is enabled, the link is full duplex, the thresholds are ordered, and the quanta is non-zero. Frame building, CRC and the transmit path belong to the MAC.

Top module: `rxbuf_pause_gen`

## Requirements
- R1: When `enable` or `full_duplex` is low at a clock edge, `req_valid` is low after that edge and any outstanding request is withdrawn. A paused state falls back to running without a pause-off request.
- R2: While running, with no request outstanding and generation allowed, `free_space < thr_on` at an edge raises `req_valid` after that edge, with `req_quanta` equal to `pause_quanta`, and the state becomes paused.
- R3: While paused, with no request outstanding, `free_space > thr_off` at an edge raises `req_valid` with `req_quanta` equal to 0, and the state becomes running.
- R4: Both threshold compares are strict. Free space equal to a threshold, or anywhere between the thresholds, causes no request. Each crossing yields one request only.
- R5: A raised request keeps `req_valid` high and `req_quanta` unchanged until an edge where `tx_done` is high. `req_valid` is low after that edge. No new request is raised while one is outstanding, so `req_valid` is low for at least one cycle between requests.
- R6: While paused, a timer counts clock edges from the edge that issued the last pause-on. At an edge where the count has reached `refresh_period`, with no request outstanding and free space not over `thr_off`, a refresh pause-on is raised with quanta `pause_quanta`, and the count restarts. A `refresh_period` of 0 disables refresh.
- R7: A configuration with `thr_off <= thr_on` or `pause_quanta == 0` is invalid. It behaves exactly like `enable` low.
- R8: After reset, `req_valid` is 0, `req_quanta` is 0, and the state is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Pause generation enable |
| full_duplex | input | 1 | Link is in full duplex |
| free_space | input | SPACE_W | Free space in the receive buffer |
| thr_on | input | SPACE_W | Entry threshold (pause-on below it) |
| thr_off | input | SPACE_W | Exit threshold (pause-off above it) |
| pause_quanta | input | QUANTA_W | Quanta for pause-on requests |
| refresh_period | input | REFRESH_W | Cycles between pause-on refreshes, 0 = off |
| tx_done | input | 1 | Transmitter has taken the request |
| req_valid | output | 1 | Pause frame request |
| req_quanta | output | QUANTA_W | Quanta for the requested frame |

## Verification
A wrong paused/running state shows up at the ports within one cycle of the next threshold test. Two examples: a missing pause-off once free space passes the exit threshold, and a duplicate pause-on inside the hysteresis band. A refresh timer that is off by one moves the refresh request by exactly one cycle, so a per-cycle comparison against a behavioural model catches it at that edge. A handshake fault shows up in one of two ways: `req_valid` drops or the quanta changes before `tx_done`, or `req_valid` stays high one cycle after it.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  typedef enum logic {
    ST_RUN    = 1'b0,
    ST_PAUSED = 1'b1
  } rpg_state_e;
endpackage

// File: rtl/rpg_gate.sv
module rpg_gate #(
  parameter int SPACE_W  = 12,
  parameter int QUANTA_W = 16
) (
  input  logic                enable,
  input  logic                full_duplex,
  input  logic [SPACE_W-1:0]  thr_on,
  input  logic [SPACE_W-1:0]  thr_off,
  input  logic [QUANTA_W-1:0] pause_quanta,
  output logic                gen_ok
);
  function automatic logic pair_valid(input logic [SPACE_W-1:0] lo,
                                      input logic [SPACE_W-1:0] hi);
    return hi > lo;
  endfunction

  function automatic logic quanta_valid(input logic [QUANTA_W-1:0] q);
    return q != '0;
  endfunction

  logic link_ok;
  logic cfg_ok;

  assign link_ok = enable && full_duplex;
  assign cfg_ok  = pair_valid(thr_on, thr_off) && quanta_valid(pause_quanta);
  assign gen_ok  = link_ok && cfg_ok;
endmodule

// File: rtl/rpg_refresh_timer.sv
module rpg_refresh_timer #(
  parameter int REFRESH_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 clr,
  input  logic [REFRESH_W-1:0] period,
  output logic                 due
);
  logic [REFRESH_W-1:0] cnt;
  logic                 below_limit;

  assign below_limit = cnt < period;
  assign due         = (period != '0) && !below_limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || !run) begin
      cnt <= '0;
    end else if (below_limit) begin
      cnt <= cnt + REFRESH_W'(1);
    end
  end

  AST_TIMER_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && below_limit) |=> (cnt == $past(cnt) + REFRESH_W'(1))); // R6
  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R6
endmodule

// File: rtl/rpg_fsm.sv
module rpg_fsm
  import rpg_pkg::*;
#(
  parameter int SPACE_W  = 12,
  parameter int QUANTA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gen_ok,
  input  logic [SPACE_W-1:0]  free_space,
  input  logic [SPACE_W-1:0]  thr_on,
  input  logic [SPACE_W-1:0]  thr_off,
  input  logic [QUANTA_W-1:0] pause_quanta,
  input  logic                refresh_due,
  input  logic                tx_done,
  output logic                req_valid,
  output logic [QUANTA_W-1:0] req_quanta,
  output logic                paused,
  output logic                timer_clr
);
  function automatic logic space_low(input logic [SPACE_W-1:0] fs,
                                     input logic [SPACE_W-1:0] t);
    return fs < t;
  endfunction

  function automatic logic space_high(input logic [SPACE_W-1:0] fs,
                                      input logic [SPACE_W-1:0] t);
    return fs > t;
  endfunction

  rpg_state_e state;
  logic       idle_ok;
  logic       below;
  logic       above;
  logic       issue_on;
  logic       issue_off;
  logic       issue_ref;
  logic       acked;

  assign idle_ok   = gen_ok && !req_valid;
  assign below     = space_low(free_space, thr_on);
  assign above     = space_high(free_space, thr_off);
  assign issue_on  = idle_ok && (state == ST_RUN) && below;
  assign issue_off = idle_ok && (state == ST_PAUSED) && above;
  assign issue_ref = idle_ok && (state == ST_PAUSED) && !above && refresh_due;
  assign acked     = req_valid && tx_done;
  assign paused    = (state == ST_PAUSED);
  assign timer_clr = issue_on || issue_ref;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      req_valid  <= 1'b0;
      req_quanta <= '0;
    end else if (!gen_ok) begin
      state     <= ST_RUN;
      req_valid <= 1'b0;
    end else if (req_valid) begin
      if (acked) req_valid <= 1'b0;
    end else if (issue_on) begin
      state      <= ST_PAUSED;
      req_valid  <= 1'b1;
      req_quanta <= pause_quanta;
    end else if (issue_off) begin
      state      <= ST_RUN;
      req_valid  <= 1'b1;
      req_quanta <= '0;
    end else if (issue_ref) begin
      req_valid  <= 1'b1;
      req_quanta <= pause_quanta;
    end
  end

  AST_ON_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && $past(state) == ST_RUN) |-> ($past(free_space) < $past(thr_on))); // R2
  AST_ON_QUANTA: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && $past(state) == ST_RUN) |-> (req_quanta == $past(pause_quanta) && paused)); // R2
  AST_OFF_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && req_quanta == '0) |-> ($past(free_space) > $past(thr_off) && !paused)); // R3
  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !tx_done && gen_ok) |=> (req_valid && $stable(req_quanta))); // R5
  AST_DROP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tx_done) |=> !req_valid); // R5
  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_ok |=> (!req_valid && !paused)); // R7
endmodule

// File: rtl/rxbuf_pause_gen.sv
module rxbuf_pause_gen #(
  parameter int SPACE_W   = 12,
  parameter int QUANTA_W  = 16,
  parameter int REFRESH_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 full_duplex,
  input  logic [SPACE_W-1:0]   free_space,
  input  logic [SPACE_W-1:0]   thr_on,
  input  logic [SPACE_W-1:0]   thr_off,
  input  logic [QUANTA_W-1:0]  pause_quanta,
  input  logic [REFRESH_W-1:0] refresh_period,
  input  logic                 tx_done,
  output logic                 req_valid,
  output logic [QUANTA_W-1:0]  req_quanta
);
  logic gen_ok;
  logic paused;
  logic timer_clr;
  logic refresh_due;

  rpg_gate #(.SPACE_W(SPACE_W), .QUANTA_W(QUANTA_W)) u_gate (
    .enable(enable), .full_duplex(full_duplex), .thr_on(thr_on),
    .thr_off(thr_off), .pause_quanta(pause_quanta), .gen_ok(gen_ok)
  );

  rpg_refresh_timer #(.REFRESH_W(REFRESH_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(paused), .clr(timer_clr),
    .period(refresh_period), .due(refresh_due)
  );

  rpg_fsm #(.SPACE_W(SPACE_W), .QUANTA_W(QUANTA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .gen_ok(gen_ok), .free_space(free_space),
    .thr_on(thr_on), .thr_off(thr_off), .pause_quanta(pause_quanta),
    .refresh_due(refresh_due), .tx_done(tx_done), .req_valid(req_valid),
    .req_quanta(req_quanta), .paused(paused), .timer_clr(timer_clr)
  );

  AST_HALF_DUPLEX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex || !enable) |=> !req_valid); // R1
  AST_NO_OFF_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !full_duplex) |=> !paused); // R1
endmodule

// File: tb/rxbuf_pause_gen_bench.sv
module rxbuf_pause_gen_bench;
  localparam int SW = 12;
  localparam int QW = 16;
  localparam int RW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          full_duplex = 1'b0;
  logic [SW-1:0] free_space = '0;
  logic [SW-1:0] thr_on = '0;
  logic [SW-1:0] thr_off = '0;
  logic [QW-1:0] pause_quanta = '0;
  logic [RW-1:0] refresh_period = '0;
  logic          tx_done = 1'b0;
  logic          req_valid;
  logic [QW-1:0] req_quanta;

  always #4 clk = ~clk;

  rxbuf_pause_gen u_rxbuf_pause_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .full_duplex(full_duplex),
    .free_space(free_space), .thr_on(thr_on), .thr_off(thr_off),
    .pause_quanta(pause_quanta), .refresh_period(refresh_period),
    .tx_done(tx_done), .req_valid(req_valid), .req_quanta(req_quanta)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R8 reset";
  bit    auto_ack = 1'b0;
  bit    manual_done = 1'b0;
  int    m_paused = 0;
  int    m_req = 0;
  int    m_q = 0;
  int    m_cnt = 0;
  int    rises = 0;
  int    cycles = 0;
  bit    prev_rv = 1'b0;

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_paused = 0; m_req = 0; m_q = 0; m_cnt = 0;
    end else if (!(enable && full_duplex && (int'(thr_off) > int'(thr_on)) && pause_quanta != 0)) begin
      m_paused = 0; m_req = 0; m_cnt = 0;
    end else begin
      int old_cnt;
      old_cnt = m_cnt;
      if (m_paused == 1 && m_cnt < int'(refresh_period)) m_cnt = m_cnt + 1;
      if (m_paused == 0) m_cnt = 0;
      if (m_req == 1) begin
        if (tx_done) m_req = 0;
      end else if (m_paused == 0 && int'(free_space) < int'(thr_on)) begin
        m_paused = 1; m_req = 1; m_q = int'(pause_quanta); m_cnt = 0;
      end else if (m_paused == 1 && int'(free_space) > int'(thr_off)) begin
        m_paused = 0; m_req = 1; m_q = 0;
      end else if (m_paused == 1 && refresh_period != 0 && old_cnt >= int'(refresh_period)) begin
        m_req = 1; m_q = int'(pause_quanta); m_cnt = 0;
      end
    end
  end

  // compare and drive the transmitter side away from the rising edge
  always @(negedge clk) begin
    cycles++;
    n_cmp++;
    if (int'(req_valid) != m_req) begin
      n_bad++;
      $display("FAIL %s: req_valid actual %0d expected %0d at cycle %0d", phase, req_valid, m_req, cycles);
    end else if (req_valid && int'(req_quanta) != m_q) begin
      n_bad++;
      $display("FAIL %s: req_quanta actual %0h expected %0h at cycle %0d", phase, req_quanta, m_q, cycles);
    end
    if (req_valid && !prev_rv) rises++;
    prev_rv = req_valid;
    tx_done <= auto_ack ? (req_valid && !tx_done) : manual_done;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    wait_cyc(3);
    check(req_valid == 1'b0 && req_quanta == '0, "R8 reset outputs", int'(req_valid), 0);
    rst_n = 1'b1;
    enable = 1'b1; full_duplex = 1'b1;
    thr_on = 12'd100; thr_off = 12'd200; pause_quanta = 16'h1234;
    refresh_period = '0; free_space = 12'd500; auto_ack = 1'b1;
    wait_cyc(5);

    phase = "R4 hysteresis band"; rises = 0;
    free_space = 12'd150; wait_cyc(6);
    free_space = 12'd100; wait_cyc(6);
    check(rises == 0, "R4 no request at or above thr_on", rises, 0);
    phase = "R2 pause-on"; rises = 0;
    free_space = 12'd99; wait_cyc(8);
    check(rises == 1, "R2 single pause-on", rises, 1);
    phase = "R4 band while paused"; rises = 0;
    free_space = 12'd150; wait_cyc(5);
    free_space = 12'd200; wait_cyc(5);
    check(rises == 0, "R4 no request at thr_off", rises, 0);
    phase = "R3 pause-off"; rises = 0;
    free_space = 12'd201; wait_cyc(8);
    check(rises == 1, "R3 single pause-off", rises, 1);

    phase = "R5 handshake"; auto_ack = 1'b0; rises = 0;
    free_space = 12'd40; wait_cyc(4);
    free_space = 12'd300; wait_cyc(12);
    check(req_valid == 1'b1 && req_quanta == 16'h1234, "R5 held until done", int'(req_quanta), 'h1234);
    manual_done = 1'b1; wait_cyc(1); manual_done = 1'b0; wait_cyc(3);
    check(req_valid == 1'b1 && req_quanta == '0, "R5 pause-off follows after done", int'(req_quanta), 0);
    manual_done = 1'b1; wait_cyc(1); manual_done = 1'b0; wait_cyc(3);
    check(rises == 2, "R5 two requests", rises, 2);

    phase = "R6 refresh"; auto_ack = 1'b1; refresh_period = 16'd20;
    pause_quanta = 16'h00ff; rises = 0;
    free_space = 12'd30; wait_cyc(75);
    check(rises == 4, "R6 pause-on plus refreshes", rises, 4);
    free_space = 12'd300; wait_cyc(6);
    refresh_period = '0; rises = 0;
    free_space = 12'd30; wait_cyc(60);
    check(rises == 1, "R6 period 0 disables refresh", rises, 1);

    phase = "R1 duplex drop"; rises = 0;
    full_duplex = 1'b0; wait_cyc(3);
    free_space = 12'd300; wait_cyc(6);
    full_duplex = 1'b1; wait_cyc(6);
    check(rises == 0, "R1 no pause-off after duplex drop", rises, 0);
    full_duplex = 1'b0; free_space = 12'd20; wait_cyc(6);
    check(rises == 0, "R1 half duplex no pause-on", rises, 0);
    full_duplex = 1'b1; free_space = 12'd300; wait_cyc(4);
    auto_ack = 1'b0; free_space = 12'd20; wait_cyc(4);
    enable = 1'b0; wait_cyc(3);
    check(req_valid == 1'b0, "R1 outstanding withdrawn", int'(req_valid), 0);
    free_space = 12'd300; wait_cyc(3);
    enable = 1'b1; auto_ack = 1'b1; wait_cyc(4);

    phase = "R7 invalid config"; rises = 0;
    thr_off = 12'd100; free_space = 12'd20; wait_cyc(8);
    check(rises == 0, "R7 equal thresholds", rises, 0);
    thr_off = 12'd200; pause_quanta = '0; wait_cyc(8);
    check(rises == 0, "R7 zero quanta", rises, 0);
    pause_quanta = 16'h0042; wait_cyc(6);
    check(rises == 1, "R7 valid config resumes", rises, 1);
    free_space = 12'd300; wait_cyc(6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule